// File: doc/BRIEF.md
# Two-Class Coherence Message Channel

This block is the point-to-point link between one child cache and its parent in a directory-based coherence system. It carries messages both ways: a child-to-parent lane (`up_*`) and a parent-to-child lane (`dn_*`). Each message carries a command class bit, source and destination node numbers, an address, a coherence state and a data word. On the way in, the class bit picks one of two queues. Requests go to a low-priority queue and responses go to a high-priority queue. Both queues drain through one shared output stream per lane.

The output picks strictly by class. While any response is queued, the lane presents the oldest response. Otherwise it presents the oldest request. As a result, requests piled up in the channel can never hold back a response, and a request can never pass a response that entered before it. Inside each class, messages leave in the order they arrived. The receiver steers each delivered message using the class bit, which is copied to the output. The two lanes share nothing except the clock and reset.

Top module: `coh_msg_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, each lane presents no message (`*_out_valid` = 0) and accepts either class (`*_in_ready` = 1).
- R2: The class bit `*_in_rsp` = 1 marks a response and 0 marks a request. A delivered message shows its own class on `*_out_rsp`.
- R3: Each class queue holds 4 messages. `*_in_ready` is low only when the queue named by the current `*_in_rsp` already holds 4 messages.
- R4: `*_out_valid` is high exactly when the lane holds at least one message. A message accepted at a clock edge can be presented from that edge on. While any response is held, the presented message is a response.
- R5: Within a class, messages leave in arrival order, and src, dst, addr, state and data arrive unchanged.
- R6: A full request queue never stops a response from being accepted, and never stops a response from being delivered.
- R7: The two lanes are independent. A stalled child-to-parent lane does not stop parent-to-child traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_in_valid | input | 1 | Child-to-parent message offered |
| up_in_ready | output | 1 | Child-to-parent message taken |
| up_in_rsp | input | 1 | Class of offered message (1 response, 0 request) |
| up_in_src | input | NODE_W | Source node |
| up_in_dst | input | NODE_W | Destination node |
| up_in_addr | input | ADDR_W | Line address |
| up_in_state | input | STATE_W | Coherence state field |
| up_in_data | input | DATA_W | Data word |
| up_out_valid | output | 1 | Child-to-parent message presented |
| up_out_ready | input | 1 | Parent takes presented message |
| up_out_rsp | output | 1 | Class of presented message |
| up_out_src | output | NODE_W | Source node |
| up_out_dst | output | NODE_W | Destination node |
| up_out_addr | output | ADDR_W | Line address |
| up_out_state | output | STATE_W | Coherence state field |
| up_out_data | output | DATA_W | Data word |
| dn_in_valid | input | 1 | Parent-to-child message offered |
| dn_in_ready | output | 1 | Parent-to-child message taken |
| dn_in_rsp | input | 1 | Class of offered message |
| dn_in_src | input | NODE_W | Source node |
| dn_in_dst | input | NODE_W | Destination node |
| dn_in_addr | input | ADDR_W | Line address |
| dn_in_state | input | STATE_W | Coherence state field |
| dn_in_data | input | DATA_W | Data word |
| dn_out_valid | output | 1 | Parent-to-child message presented |
| dn_out_ready | input | 1 | Child takes presented message |
| dn_out_rsp | output | 1 | Class of presented message |
| dn_out_src | output | NODE_W | Source node |
| dn_out_dst | output | NODE_W | Destination node |
| dn_out_addr | output | ADDR_W | Line address |
| dn_out_state | output | STATE_W | Coherence state field |
| dn_out_data | output | DATA_W | Data word |

## Verification
Each internal fault shows up at the ports quickly.

- A wrong occupancy count in either queue shows as `*_in_ready` at the wrong level. This appears in the very cycle that queue reaches or leaves four entries.
- A wrong pointer shows as a wrong or repeated payload on the first delivery that uses it.
- A wrong arbiter choice shows as a request on the output while a response is held. This is visible in the cycle right after the response was accepted.

The bench models both queues of both lanes with plain queues. It compares ready, valid, class and payload every cycle, so any of these faults is caught within one cycle of becoming visible.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

   // Message class carried on the class bit of every lane
   typedef enum logic {
      CLS_REQ = 1'b0,
      CLS_RSP = 1'b1
   } msg_cls_e;

   // Number of lanes in the channel: child-to-parent and parent-to-child
   localparam int unsigned LANES = 2;
   localparam int unsigned LANE_UP = 0;
   localparam int unsigned LANE_DN = 1;

   // Width of a flattened payload {src, dst, addr, state, data}
   function automatic int unsigned payload_width(input int unsigned node_w,
                                                 input int unsigned addr_w,
                                                 input int unsigned state_w,
                                                 input int unsigned data_w);
      return 2 * node_w + addr_w + state_w + data_w;
   endfunction

endpackage

// File: rtl/ccm_fifo.sv
module ccm_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);

   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ccm_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ccm_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [PW-1:0]    wr_nxt, rd_nxt;
   logic [CW-1:0]    count;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_nxt;
         end
         if (pop) begin
            rd_ptr <= rd_nxt;
         end
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

endmodule

// File: rtl/ccm_arb.sv
module ccm_arb (
   input  logic rsp_avail,
   input  logic req_avail,
   input  logic hold,
   input  logic held_rsp,
   output logic out_valid,
   output logic grant_rsp
);

   // Responses win whenever present, unless the lane pins an earlier choice
   always_comb begin
      out_valid = rsp_avail | req_avail;
      if (hold) begin
         grant_rsp = held_rsp;
      end else begin
         grant_rsp = rsp_avail;
      end
   end

endmodule

// File: rtl/ccm_lane.sv
module ccm_lane
   import ccm_pkg::*;
#(
   parameter int unsigned MW       = 8,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned HOLD_SEL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_cls,
   input  logic [MW-1:0] in_msg,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_cls,
   output logic [MW-1:0] out_msg
);

   generate
      if (HOLD_SEL > 1) begin : g_bad_hold
         $error("ccm_lane: HOLD_SEL must be 0 or 1");
      end
   endgenerate

   // Index 0 is the request queue, index 1 the response queue
   logic          q_push  [2];
   logic          q_pop   [2];
   logic          q_empty [2];
   logic          q_full  [2];
   logic [MW-1:0] q_head  [2];

   logic grant_rsp;
   logic hold, held_rsp;
   logic deliver;

   genvar c;
   generate
      for (c = 0; c < 2; c++) begin : g_cls
         localparam logic CLS_BIT = (c == 1) ? CLS_RSP : CLS_REQ;

         assign q_push[c] = in_valid && (in_cls == CLS_BIT) && !q_full[c];
         assign q_pop[c]  = deliver && (grant_rsp == CLS_BIT);

         ccm_fifo #(
            .WIDTH (MW),
            .DEPTH (DEPTH)
         ) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[c]),
            .din   (in_msg),
            .pop   (q_pop[c]),
            .dout  (q_head[c]),
            .empty (q_empty[c]),
            .full  (q_full[c])
         );
      end
   endgenerate

   assign in_ready = (in_cls == CLS_RSP) ? !q_full[1] : !q_full[0];

   ccm_arb u_arb (
      .rsp_avail (!q_empty[1]),
      .req_avail (!q_empty[0]),
      .hold      (hold),
      .held_rsp  (held_rsp),
      .out_valid (out_valid),
      .grant_rsp (grant_rsp)
   );

   // Optional variant: freeze the choice while the receiver stalls
   generate
      if (HOLD_SEL == 1) begin : g_hold
         logic stall_q, sel_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stall_q <= 1'b0;
               sel_q   <= 1'b0;
            end else begin
               stall_q <= out_valid && !out_ready;
               sel_q   <= grant_rsp;
            end
         end
         assign hold     = stall_q;
         assign held_rsp = sel_q;
      end else begin : g_strict
         assign hold     = 1'b0;
         assign held_rsp = 1'b0;
      end
   endgenerate

   assign deliver = out_valid && out_ready;
   assign out_cls = grant_rsp;
   assign out_msg = grant_rsp ? q_head[1] : q_head[0];

endmodule

// File: rtl/coh_msg_channel.sv
module coh_msg_channel
   import ccm_pkg::*;
#(
   parameter int unsigned NODE_W   = 2,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned STATE_W  = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned HOLD_SEL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up_in_valid,
   output logic               up_in_ready,
   input  logic               up_in_rsp,
   input  logic [NODE_W-1:0]  up_in_src,
   input  logic [NODE_W-1:0]  up_in_dst,
   input  logic [ADDR_W-1:0]  up_in_addr,
   input  logic [STATE_W-1:0] up_in_state,
   input  logic [DATA_W-1:0]  up_in_data,
   output logic               up_out_valid,
   input  logic               up_out_ready,
   output logic               up_out_rsp,
   output logic [NODE_W-1:0]  up_out_src,
   output logic [NODE_W-1:0]  up_out_dst,
   output logic [ADDR_W-1:0]  up_out_addr,
   output logic [STATE_W-1:0] up_out_state,
   output logic [DATA_W-1:0]  up_out_data,
   input  logic               dn_in_valid,
   output logic               dn_in_ready,
   input  logic               dn_in_rsp,
   input  logic [NODE_W-1:0]  dn_in_src,
   input  logic [NODE_W-1:0]  dn_in_dst,
   input  logic [ADDR_W-1:0]  dn_in_addr,
   input  logic [STATE_W-1:0] dn_in_state,
   input  logic [DATA_W-1:0]  dn_in_data,
   output logic               dn_out_valid,
   input  logic               dn_out_ready,
   output logic               dn_out_rsp,
   output logic [NODE_W-1:0]  dn_out_src,
   output logic [NODE_W-1:0]  dn_out_dst,
   output logic [ADDR_W-1:0]  dn_out_addr,
   output logic [STATE_W-1:0] dn_out_state,
   output logic [DATA_W-1:0]  dn_out_data
);

   localparam int unsigned MW = payload_width(NODE_W, ADDR_W, STATE_W, DATA_W);

   generate
      if (NODE_W < 1 || ADDR_W < 1 || STATE_W < 1 || DATA_W < 1) begin : g_bad_fields
         $error("coh_msg_channel: every field width must be at least 1");
      end
   endgenerate

   logic          l_in_valid  [LANES];
   logic          l_in_ready  [LANES];
   logic          l_in_cls    [LANES];
   logic [MW-1:0] l_in_msg    [LANES];
   logic          l_out_valid [LANES];
   logic          l_out_ready [LANES];
   logic          l_out_cls   [LANES];
   logic [MW-1:0] l_out_msg   [LANES];

   // Child-to-parent lane edges
   assign l_in_valid[LANE_UP]  = up_in_valid;
   assign l_in_cls[LANE_UP]    = up_in_rsp;
   assign l_in_msg[LANE_UP]    = {up_in_src, up_in_dst, up_in_addr, up_in_state, up_in_data};
   assign l_out_ready[LANE_UP] = up_out_ready;
   assign up_in_ready          = l_in_ready[LANE_UP];
   assign up_out_valid         = l_out_valid[LANE_UP];
   assign up_out_rsp           = l_out_cls[LANE_UP];
   assign {up_out_src, up_out_dst, up_out_addr, up_out_state, up_out_data} = l_out_msg[LANE_UP];

   // Parent-to-child lane edges
   assign l_in_valid[LANE_DN]  = dn_in_valid;
   assign l_in_cls[LANE_DN]    = dn_in_rsp;
   assign l_in_msg[LANE_DN]    = {dn_in_src, dn_in_dst, dn_in_addr, dn_in_state, dn_in_data};
   assign l_out_ready[LANE_DN] = dn_out_ready;
   assign dn_in_ready          = l_in_ready[LANE_DN];
   assign dn_out_valid         = l_out_valid[LANE_DN];
   assign dn_out_rsp           = l_out_cls[LANE_DN];
   assign {dn_out_src, dn_out_dst, dn_out_addr, dn_out_state, dn_out_data} = l_out_msg[LANE_DN];

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         ccm_lane #(
            .MW       (MW),
            .DEPTH    (DEPTH),
            .HOLD_SEL (HOLD_SEL)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (l_in_valid[l]),
            .in_ready  (l_in_ready[l]),
            .in_cls    (l_in_cls[l]),
            .in_msg    (l_in_msg[l]),
            .out_valid (l_out_valid[l]),
            .out_ready (l_out_ready[l]),
            .out_cls   (l_out_cls[l]),
            .out_msg   (l_out_msg[l])
         );
      end
   endgenerate

endmodule

// File: rtl/ccm_lane_chk.sv
module ccm_lane_chk #(
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned HOLD_SEL = 0
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic in_cls,
   input logic out_valid,
   input logic out_ready,
   input logic out_cls
);

   int unsigned n_rsp, n_req;

   // Occupancy per class, taken from handshakes at the lane edges
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_rsp <= 0;
         n_req <= 0;
      end else begin
         n_rsp <= n_rsp + ((in_valid && in_ready && in_cls) ? 1 : 0)
                        - ((out_valid && out_ready && out_cls) ? 1 : 0);
         n_req <= n_req + ((in_valid && in_ready && !in_cls) ? 1 : 0)
                        - ((out_valid && out_ready && !out_cls) ? 1 : 0);
      end
   end

   p_idle_after_rst_r1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cls && n_rsp == DEPTH) || (!in_cls && n_req == DEPTH) |-> !in_ready);

   p_room_accepts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cls && n_rsp < DEPTH) || (!in_cls && n_req < DEPTH) |-> in_ready);

   p_rsp_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (n_req == DEPTH && in_cls && n_rsp < DEPTH) |-> in_ready);

   p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (n_rsp == 0 && n_req == 0) |-> !out_valid);

   p_held_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (n_rsp != 0 || n_req != 0) |-> out_valid);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (n_rsp <= DEPTH) && (n_req <= DEPTH));

   generate
      if (HOLD_SEL == 0) begin : g_strict_chk
         p_rsp_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (n_rsp != 0) |-> (out_valid && out_cls));
      end
   endgenerate

endmodule

bind ccm_lane ccm_lane_chk #(
   .DEPTH    (DEPTH),
   .HOLD_SEL (HOLD_SEL)
) u_lane_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_cls    (in_cls),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_cls   (out_cls)
);

// File: tb/coh_msg_channel_tb.sv
module coh_msg_channel_tb_top;

   localparam int NODE_W  = 2;
   localparam int ADDR_W  = 16;
   localparam int STATE_W = 2;
   localparam int DATA_W  = 32;
   localparam int DEPTH   = 4;
   localparam int FW      = 2 * NODE_W + ADDR_W + STATE_W + DATA_W;

   typedef logic [FW-1:0] msg_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0] in_v, in_r, in_c, out_v, out_r, out_c;
   msg_t       in_m [2];
   msg_t       out_m [2];

   int n_tests = 0;
   int n_fail  = 0;
   int deliv [2];
   int vp [2];
   int cp [2];
   int rp [2];

   // Reference queues: index lane*2 + class (class 1 = response)
   msg_t mq [4][$];

   coh_msg_channel dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .up_in_valid  (in_v[0]),
      .up_in_ready  (in_r[0]),
      .up_in_rsp    (in_c[0]),
      .up_in_src    (in_m[0][FW-1 -: NODE_W]),
      .up_in_dst    (in_m[0][FW-NODE_W-1 -: NODE_W]),
      .up_in_addr   (in_m[0][STATE_W+DATA_W+ADDR_W-1 -: ADDR_W]),
      .up_in_state  (in_m[0][DATA_W+STATE_W-1 -: STATE_W]),
      .up_in_data   (in_m[0][DATA_W-1:0]),
      .up_out_valid (out_v[0]),
      .up_out_ready (out_r[0]),
      .up_out_rsp   (out_c[0]),
      .up_out_src   (out_m[0][FW-1 -: NODE_W]),
      .up_out_dst   (out_m[0][FW-NODE_W-1 -: NODE_W]),
      .up_out_addr  (out_m[0][STATE_W+DATA_W+ADDR_W-1 -: ADDR_W]),
      .up_out_state (out_m[0][DATA_W+STATE_W-1 -: STATE_W]),
      .up_out_data  (out_m[0][DATA_W-1:0]),
      .dn_in_valid  (in_v[1]),
      .dn_in_ready  (in_r[1]),
      .dn_in_rsp    (in_c[1]),
      .dn_in_src    (in_m[1][FW-1 -: NODE_W]),
      .dn_in_dst    (in_m[1][FW-NODE_W-1 -: NODE_W]),
      .dn_in_addr   (in_m[1][STATE_W+DATA_W+ADDR_W-1 -: ADDR_W]),
      .dn_in_state  (in_m[1][DATA_W+STATE_W-1 -: STATE_W]),
      .dn_in_data   (in_m[1][DATA_W-1:0]),
      .dn_out_valid (out_v[1]),
      .dn_out_ready (out_r[1]),
      .dn_out_rsp   (out_c[1]),
      .dn_out_src   (out_m[1][FW-1 -: NODE_W]),
      .dn_out_dst   (out_m[1][FW-NODE_W-1 -: NODE_W]),
      .dn_out_addr  (out_m[1][STATE_W+DATA_W+ADDR_W-1 -: ADDR_W]),
      .dn_out_state (out_m[1][DATA_W+STATE_W-1 -: STATE_W]),
      .dn_out_data  (out_m[1][DATA_W-1:0])
   );

   task automatic chk(input string tag, input int lane, input logic [63:0] act,
                      input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s lane %0d: actual %0h expected %0h at %0t", tag, lane, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, compare, then advance the model
   task automatic step();
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         in_v[d]  = ($urandom() % 100) < vp[d];
         in_c[d]  = ($urandom() % 100) < cp[d];
         in_m[d]  = FW'({$urandom(), $urandom()});
         out_r[d] = ($urandom() % 100) < rp[d];
      end
      #1;
      for (int d = 0; d < 2; d++) begin
         int  nrq = mq[d*2].size();
         int  nrs = mq[d*2+1].size();
         logic exp_rdy = in_c[d] ? (nrs < DEPTH) : (nrq < DEPTH);
         logic exp_ov  = (nrq + nrs) > 0;
         logic exp_cls = nrs > 0;
         logic other_full = in_c[d] ? (nrq == DEPTH) : (nrs == DEPTH);
         chk(other_full ? "R6 ready" : "R3 ready", d, 64'(in_r[d]), 64'(exp_rdy));
         chk("R4 valid", d, 64'(out_v[d]), 64'(exp_ov));
         if (exp_ov) begin
            chk("R2 class", d, 64'(out_c[d]), 64'(exp_cls));
            chk("R5 payload", d, 64'(out_m[d]), 64'(mq[d*2 + (exp_cls ? 1 : 0)][0]));
         end
         if (exp_ov && out_r[d]) begin
            void'(mq[d*2 + (exp_cls ? 1 : 0)].pop_front());
            deliv[d]++;
         end
         if (in_v[d] && exp_rdy) begin
            mq[d*2 + (in_c[d] ? 1 : 0)].push_back(in_m[d]);
         end
      end
   endtask

   task automatic set_mode(input int v0, input int c0, input int r0,
                           input int v1, input int c1, input int r1);
      vp[0] = v0; cp[0] = c0; rp[0] = r0;
      vp[1] = v1; cp[1] = c1; rp[1] = r1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   initial begin
      int d_before, u_before;
      in_v = '0; in_c = '0; out_r = '0;
      in_m[0] = '0; in_m[1] = '0;
      deliv[0] = 0; deliv[1] = 0;
      set_mode(0, 0, 0, 0, 0, 0);

      // R1: reset state on both lanes, both classes
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1 idle", 0, 64'(out_v), 64'(0));
      chk("R1 ready req", 0, 64'(in_r), 64'(2'b11));
      in_c = 2'b11;
      #1;
      chk("R1 ready rsp", 1, 64'(in_r), 64'(2'b11));
      in_c = 2'b00;
      rst_n = 1'b1;
      step();

      // Mixed traffic with a busy receiver
      set_mode(70, 50, 60, 70, 50, 60);
      repeat (300) step();

      // Drain
      set_mode(0, 0, 100, 0, 0, 100);
      repeat (12) step();

      // R6: fill request queue with receiver stalled, then offer responses
      set_mode(100, 0, 0, 100, 0, 0);
      repeat (8) step();
      set_mode(100, 100, 0, 100, 100, 0);
      repeat (8) step();
      set_mode(0, 0, 100, 0, 0, 100);
      repeat (12) step();

      // R4 / R5: response-heavy and request-heavy bursts
      set_mode(90, 85, 40, 90, 15, 40);
      repeat (200) step();
      set_mode(0, 0, 100, 0, 0, 100);
      repeat (12) step();

      // R7: child-to-parent stalled while parent-to-child flows
      d_before = deliv[1];
      u_before = deliv[0];
      set_mode(100, 50, 0, 60, 50, 100);
      repeat (40) step();
      chk("R7 down flows", 1, 64'(deliv[1] - d_before > 10), 64'(1));
      chk("R7 up stalled", 0, 64'(deliv[0] - u_before), 64'(0));
      set_mode(0, 0, 100, 0, 0, 100);
      repeat (12) step();

      summary();
   end

endmodule